// File: doc/BRIEF.md
# Iterative RC5-32/12/16 Encryption Core

This block encrypts 64-bit blocks with the RC5 cipher at a 32-bit word size, twelve rounds and a sixteen-byte secret key. Only one round of datapath exists. A small sequencer feeds that round back on itself, one round per clock, until the block is done. The subkey table is also built on chip: after a key is written, a sequential expansion engine fills a 26-word table in 78 clock cycles, one mixing step per cycle.

In use, the host pulses `key_load` with the key on `key_in` and waits for `key_busy` to fall. From then on it offers plaintext blocks through a valid/ready handshake. Each ciphertext appears on `out_block` together with a one-cycle `out_valid` pulse. The core accepts a new block in the same cycle that it releases a result, so blocks can follow each other without a gap.

Top module: `rc5_core`

## Requirements
- R1: After reset, `in_ready`, `key_busy` and `out_valid` are all low, and `in_ready` stays low until a key expansion has completed.
- R2: Key byte k sits at `key_in[8k+7:8k]`. Expansion word L[m] is built from bytes 4m..4m+3, with byte 4m as the least significant byte.
- R3: Expansion first fills S[t] = 0xB7E15163 + t*0x9E3779B9 for t = 0..25. It then runs exactly 78 mixing steps, and `key_busy` is high for exactly 78 cycles after the edge that takes the load.
- R4: `in_ready` is low while `key_busy` is high, while no expanded key exists, and while a block is in flight. `in_valid` has no effect while `in_ready` is low.
- R5: The ciphertext is the RC5 result: pre-whitening A+=S[0], B+=S[1], followed by 12 rounds A=((A^B)<<<B[4:0])+S[2i] and B=((B^A)<<<A[4:0])+S[2i+1]. Word A is `[31:0]` and word B is `[63:32]` on both `in_block` and `out_block`.
- R6: Count the edge that accepts a block as edge 1. `out_valid` is high in the cycle that follows edge 13.
- R7: `out_valid` is a single-cycle pulse. With an all-zero key and an all-zero block, `out_block` equals 64'h6D8F4B15_EEDBA521.
- R8: A `key_load` pulse is ignored while a block is in flight, including the cycle in which the block is accepted. The block completes with the old key, and `key_busy` stays low.
- R9: A `key_load` pulse during an expansion restarts it with the new key. `key_busy` then stays high for 78 cycles counted from the new load.
- R10: `in_ready` is high in the cycle in which `out_valid` is high, so a waiting block is accepted at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| key_load | input | 1 | Pulse to start expanding `key_in` |
| key_in | input | 128 | Secret key, little-endian bytes |
| key_busy | output | 1 | Key expansion in progress |
| in_valid | input | 1 | Plaintext block offered |
| in_ready | output | 1 | Core can accept a block |
| in_block | input | 64 | Plaintext, A in low word |
| out_valid | output | 1 | One-cycle ciphertext strobe |
| out_block | output | 64 | Ciphertext, A in low word |

## Verification
Some properties are checked on every cycle. `in_ready` is never high while the key is busy. The output strobe lasts one cycle and always lands exactly thirteen edges after an acceptance. A key load that arrives while a block is in flight never raises `key_busy`. Every fall of `key_busy` comes exactly 78 busy cycles after the most recent load. The bit-exact arithmetic can only be shown by the bench scenarios: the little-endian key packing, the table initial values, the mixing steps and the round function. The bench compares ciphertexts against an independent model over a sweep of keys and blocks, and against the published zero-key vector. Only the scenarios can also show the results of a restart in the middle of an expansion and of a load that was ignored.

// File: rtl/rc5_pkg.sv
package rc5_pkg;
  localparam int WORD_W = 32;
  localparam int ROT_W  = $clog2(WORD_W);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ROT_W-1:0]  rot_t;

  localparam word_t MAGIC_P = 32'hB7E15163;
  localparam word_t MAGIC_Q = 32'h9E3779B9;

  // rotate left by a data-dependent amount (0 leaves the word unchanged)
  function automatic word_t rotl(input word_t x, input rot_t n);
    logic [2*WORD_W-1:0] dbl;
    dbl = {x, x} << n;
    return dbl[2*WORD_W-1:WORD_W];
  endfunction

  // starting value of table entry k before mixing
  function automatic word_t table_seed(input int k);
    return MAGIC_P + word_t'(k) * MAGIC_Q;
  endfunction

  // mixing step, table side: fixed rotation by three
  function automatic word_t mix_tab(input word_t s, input word_t a, input word_t b);
    return rotl(s + a + b, rot_t'(3));
  endfunction

  // mixing step, key side: rotation by the low bits of a+b
  function automatic word_t mix_key(input word_t l, input word_t a, input word_t b);
    word_t ab;
    ab = a + b;
    return rotl(l + ab, ab[ROT_W-1:0]);
  endfunction

  // one half-round: rotate (x^y) by y, then add the subkey
  function automatic word_t half_round(input word_t x, input word_t y, input word_t s);
    return rotl(x ^ y, y[ROT_W-1:0]) + s;
  endfunction
endpackage

// File: rtl/rc5_key_expand.sv
module rc5_key_expand
  import rc5_pkg::*;
#(
  parameter int ROUNDS    = 12,
  parameter int KEY_BYTES = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [KEY_BYTES*8-1:0]        key,
  input  logic [$clog2(ROUNDS+1)-1:0]   rd_idx,
  output word_t                         s_even,
  output word_t                         s_odd,
  output logic                          busy,
  output logic                          have_key,
  output logic                          step_evt
);
  localparam int TAB   = 2 * (ROUNDS + 1);
  localparam int KW    = (KEY_BYTES + 3) / 4;
  localparam int STEPS = 3 * ((TAB > KW) ? TAB : KW);
  localparam int IW    = $clog2(TAB);
  localparam int JW    = (KW > 1) ? $clog2(KW) : 1;
  localparam int CW    = $clog2(STEPS + 1);
  localparam int KPW   = KW * WORD_W;

  word_t          s_tab [TAB];
  word_t          l_tab [KW];
  logic [IW-1:0]  i_q;
  logic [JW-1:0]  j_q;
  word_t          a_q, b_q;
  logic [CW-1:0]  cnt_q;
  logic           busy_q, have_q;

  logic [KPW-1:0] key_pad;
  word_t          a_new, b_new;
  logic [IW-1:0]  ev_idx, od_idx;

  assign key_pad = KPW'(key);
  assign a_new   = mix_tab(s_tab[i_q], a_q, b_q);
  assign b_new   = mix_key(l_tab[j_q], a_new, b_q);
  assign step_evt = busy_q & ~load;

  // table arrays carry no reset: they are rewritten on every load
  always_ff @(posedge clk) begin
    if (load) begin
      for (int k = 0; k < TAB; k++) s_tab[k] <= table_seed(k);
      for (int m = 0; m < KW; m++)  l_tab[m] <= key_pad[m*WORD_W +: WORD_W];
    end else if (busy_q) begin
      s_tab[i_q] <= a_new;
      l_tab[j_q] <= b_new;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i_q    <= '0;
      j_q    <= '0;
      a_q    <= '0;
      b_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      have_q <= 1'b0;
    end else if (load) begin
      i_q    <= '0;
      j_q    <= '0;
      a_q    <= '0;
      b_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b1;
      have_q <= 1'b0;
    end else if (busy_q) begin
      a_q   <= a_new;
      b_q   <= b_new;
      i_q   <= (i_q == IW'(TAB - 1)) ? '0 : i_q + 1'b1;
      j_q   <= (j_q == JW'(KW - 1))  ? '0 : j_q + 1'b1;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(STEPS - 1)) begin
        busy_q <= 1'b0;
        have_q <= 1'b1;
      end
    end
  end

  assign ev_idx   = IW'({rd_idx, 1'b0});
  assign od_idx   = ev_idx | IW'(1);
  assign s_even   = s_tab[ev_idx];
  assign s_odd    = s_tab[od_idx];
  assign busy     = busy_q;
  assign have_key = have_q;
endmodule

// File: rtl/rc5_round_unit.sv
module rc5_round_unit
  import rc5_pkg::*;
(
  input  logic  whiten,
  input  word_t a_in,
  input  word_t b_in,
  input  word_t s_even,
  input  word_t s_odd,
  output word_t a_out,
  output word_t b_out
);
  word_t a_rnd;

  // the B half uses the freshly computed A
  assign a_rnd = half_round(a_in, b_in, s_even);

  always_comb begin
    if (whiten) begin
      a_out = a_in + s_even;
      b_out = b_in + s_odd;
    end else begin
      a_out = a_rnd;
      b_out = half_round(b_in, a_rnd, s_odd);
    end
  end
endmodule

// File: rtl/rc5_block_seq.sv
module rc5_block_seq
  import rc5_pkg::*;
#(
  parameter int ROUNDS = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         key_ok,
  input  logic                         in_valid,
  input  logic [2*WORD_W-1:0]          in_block,
  input  word_t                        a_nxt,
  input  word_t                        b_nxt,
  output word_t                        a_cur,
  output word_t                        b_cur,
  output logic                         whiten,
  output logic [$clog2(ROUNDS+1)-1:0]  rd_idx,
  output logic                         in_ready,
  output logic                         out_valid,
  output logic [2*WORD_W-1:0]          out_block,
  output logic                         blk_accept,
  output logic                         blk_active
);
  localparam int RW = $clog2(ROUNDS + 1);

  typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_t;

  seq_state_t    state_q;
  logic [RW-1:0] rnd_q;
  word_t         a_q, b_q;
  logic          ov_q;
  logic          last_rnd;

  assign in_ready   = (state_q == SEQ_IDLE) & key_ok;
  assign blk_accept = in_valid & in_ready;
  assign blk_active = (state_q == SEQ_RUN);
  assign last_rnd   = blk_active & (rnd_q == RW'(ROUNDS));
  assign whiten     = ~blk_active;
  assign rd_idx     = blk_active ? rnd_q : '0;
  assign a_cur      = blk_active ? a_q : in_block[WORD_W-1:0];
  assign b_cur      = blk_active ? b_q : in_block[2*WORD_W-1:WORD_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      rnd_q   <= '0;
      a_q     <= '0;
      b_q     <= '0;
      ov_q    <= 1'b0;
    end else begin
      ov_q <= 1'b0;
      if (blk_accept) begin
        a_q     <= a_nxt;
        b_q     <= b_nxt;
        rnd_q   <= RW'(1);
        state_q <= SEQ_RUN;
      end else if (blk_active) begin
        a_q <= a_nxt;
        b_q <= b_nxt;
        if (last_rnd) begin
          state_q <= SEQ_IDLE;
          ov_q    <= 1'b1;
        end else begin
          rnd_q <= rnd_q + 1'b1;
        end
      end
    end
  end

  assign out_valid = ov_q;
  assign out_block = {b_q, a_q};
endmodule

// File: rtl/rc5_core.sv
module rc5_core
  import rc5_pkg::*;
#(
  parameter int ROUNDS    = 12,
  parameter int KEY_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   key_load,
  input  logic [KEY_BYTES*8-1:0] key_in,
  output logic                   key_busy,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [2*WORD_W-1:0]    in_block,
  output logic                   out_valid,
  output logic [2*WORD_W-1:0]    out_block
);
  localparam int RW = $clog2(ROUNDS + 1);

  word_t         s_even, s_odd, a_cur, b_cur, a_nxt, b_nxt;
  logic [RW-1:0] rd_idx;
  logic          whiten, have_key, key_ok;
  logic          blk_accept, blk_active, key_start, mix_step;

  // a load is dropped while a block is in flight or being accepted
  assign key_start = key_load & ~blk_active & ~blk_accept;
  assign key_ok    = have_key & ~key_busy;

  rc5_key_expand #(.ROUNDS(ROUNDS), .KEY_BYTES(KEY_BYTES)) u_kexp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (key_start),
    .key      (key_in),
    .rd_idx   (rd_idx),
    .s_even   (s_even),
    .s_odd    (s_odd),
    .busy     (key_busy),
    .have_key (have_key),
    .step_evt (mix_step)
  );

  rc5_round_unit u_round (
    .whiten (whiten),
    .a_in   (a_cur),
    .b_in   (b_cur),
    .s_even (s_even),
    .s_odd  (s_odd),
    .a_out  (a_nxt),
    .b_out  (b_nxt)
  );

  rc5_block_seq #(.ROUNDS(ROUNDS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_ok     (key_ok),
    .in_valid   (in_valid),
    .in_block   (in_block),
    .a_nxt      (a_nxt),
    .b_nxt      (b_nxt),
    .a_cur      (a_cur),
    .b_cur      (b_cur),
    .whiten     (whiten),
    .rd_idx     (rd_idx),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_block  (out_block),
    .blk_accept (blk_accept),
    .blk_active (blk_active)
  );
endmodule

// File: rtl/rc5_core_checks.sv
module rc5_core_checks #(
  parameter int ROUNDS    = 12,
  parameter int KEY_BYTES = 16
) (
  input logic clk,
  input logic rst_n,
  input logic key_load,
  input logic key_busy,
  input logic key_start,
  input logic mix_step,
  input logic in_ready,
  input logic out_valid,
  input logic blk_accept,
  input logic blk_active
);
  localparam int TAB   = 2 * (ROUNDS + 1);
  localparam int KW    = (KEY_BYTES + 3) / 4;
  localparam int STEPS = 3 * ((TAB > KW) ? TAB : KW);
  localparam int BCW   = $clog2(STEPS + 1) + 1;
  localparam int LCW   = $clog2(ROUNDS + 2) + 1;

  logic [BCW-1:0] busy_cnt;
  logic [LCW-1:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      lat_cnt  <= '0;
    end else begin
      if (key_start)     busy_cnt <= '0;
      else if (mix_step) busy_cnt <= busy_cnt + 1'b1;
      if (blk_accept)                        lat_cnt <= LCW'(1);
      else if (lat_cnt == LCW'(ROUNDS + 1))  lat_cnt <= '0;
      else if (lat_cnt != '0)                lat_cnt <= lat_cnt + 1'b1;
    end
  end

  assert_ready_low_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    key_busy |-> !in_ready);

  assert_ready_low_inflight_R4: assert property (@(posedge clk) disable iff (!rst_n)
    blk_active |-> !in_ready);

  assert_busy_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(key_busy) |-> (busy_cnt == BCW'(STEPS)));

  assert_restart_keeps_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    key_start |=> key_busy);

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (lat_cnt == LCW'(ROUNDS + 1)));

  assert_latency_due_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_cnt == LCW'(ROUNDS + 1)) |-> out_valid);

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_load_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (key_load && (blk_active || blk_accept)) |=> !key_busy);

  assert_back_to_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);
endmodule

bind rc5_core rc5_core_checks #(.ROUNDS(ROUNDS), .KEY_BYTES(KEY_BYTES)) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .key_load   (key_load),
  .key_busy   (key_busy),
  .key_start  (key_start),
  .mix_step   (mix_step),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .blk_accept (blk_accept),
  .blk_active (blk_active)
);

// File: tb/rc5_core_test.sv
module rc5_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         key_load = 1'b0;
  logic [127:0] key_in = '0;
  logic         key_busy;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [63:0]  in_block = '0;
  logic         out_valid;
  logic [63:0]  out_block;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rc5_core uut (
    .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
    .key_busy(key_busy), .in_valid(in_valid), .in_ready(in_ready),
    .in_block(in_block), .out_valid(out_valid), .out_block(out_block)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      n_fails = n_fails + 1;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model written from the requirements
  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    int m = n % 32;
    if (m == 0) return x;
    return (x << m) | (x >> (32 - m));
  endfunction

  function automatic logic [63:0] ref_enc(input logic [127:0] k, input logic [63:0] pt);
    logic [31:0] s [26];
    logic [31:0] l [4];
    logic [31:0] x, y, a, b;
    int ii, jj;
    for (int m = 0; m < 4; m++)
      l[m] = {k[8*(4*m+3) +: 8], k[8*(4*m+2) +: 8], k[8*(4*m+1) +: 8], k[8*(4*m) +: 8]};
    s[0] = 32'hB7E15163;
    for (int t = 1; t < 26; t++) s[t] = s[t-1] + 32'h9E3779B9;
    x = 0; y = 0; ii = 0; jj = 0;
    for (int st = 0; st < 78; st++) begin
      x = rl(s[ii] + x + y, 3);
      s[ii] = x;
      y = rl(l[jj] + x + y, int'((x + y) & 32'd31));
      l[jj] = y;
      ii = (ii + 1) % 26;
      jj = (jj + 1) % 4;
    end
    a = pt[31:0] + s[0];
    b = pt[63:32] + s[1];
    for (int r = 1; r <= 12; r++) begin
      a = rl(a ^ b, int'(b & 32'd31)) + s[2*r];
      b = rl(b ^ a, int'(a & 32'd31)) + s[2*r+1];
    end
    return {b, a};
  endfunction

  task automatic load_key(input logic [127:0] k, output int busy_len);
    key_load = 1'b1;
    key_in   = k;
    @(negedge clk);
    key_load = 1'b0;
    busy_len = 0;
    while (key_busy && busy_len < 300) begin
      busy_len++;
      @(negedge clk);
    end
  endtask

  task automatic run_block(input logic [63:0] pt, output logic [63:0] ct, output int lat,
                           output bit rdy_at_valid, output bit pulse_ok);
    int w = 0;
    while (!in_ready && w < 300) begin w++; @(negedge clk); end
    in_valid = 1'b1;
    in_block = pt;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 60) begin @(negedge clk); lat++; end
    ct = out_block;
    rdy_at_valid = in_ready;
    @(negedge clk);
    pulse_ok = !out_valid;
  endtask

  initial begin : main
    logic [63:0] ct, ct2, exp;
    logic [127:0] keys [4];
    int lat, blen, gap, seen;
    bit rdy, pls;

    keys[0] = '0;
    for (int k = 0; k < 16; k++) keys[1][8*k +: 8] = 8'(k);
    keys[2] = {128{1'b1}};
    keys[3] = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(in_ready == 1'b0,  "R1 in_ready after reset",  64'(in_ready),  64'd0);
    check(key_busy == 1'b0,  "R1 key_busy after reset",  64'(key_busy),  64'd0);
    check(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 blocks offered before any key are not taken
    in_valid = 1'b1;
    seen = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (out_valid || in_ready) seen++;
    end
    in_valid = 1'b0;
    check(seen == 0, "R1 R4 no acceptance without key", 64'(seen), 64'd0);

    // R3 zero key expansion length, R7 published vector
    load_key(keys[0], blen);
    check(blen == 78, "R3 busy length", 64'(blen), 64'd78);
    run_block(64'd0, ct, lat, rdy, pls);
    check(ct == 64'h6D8F4B15_EEDBA521, "R7 zero-key vector", ct, 64'h6D8F4B15_EEDBA521);
    check(lat == 13, "R6 latency", 64'(lat), 64'd13);
    check(pls, "R7 single pulse", 64'(pls), 64'd1);
    check(rdy, "R10 ready with valid", 64'(rdy), 64'd1);

    // R2 R5 sweep over keys and blocks
    for (int ki = 0; ki < 4; ki++) begin
      load_key(keys[ki], blen);
      check(blen == 78, "R3 busy length sweep", 64'(blen), 64'd78);
      for (int p = 0; p < 20; p++) begin
        logic [63:0] pt;
        pt = (p < 13) ? (64'd1 << (p * 5)) : {32'(p) * 32'h01234567, ~(32'(p) * 32'h89ABCDEF)};
        run_block(pt, ct, lat, rdy, pls);
        exp = ref_enc(keys[ki], pt);
        check(ct == exp, "R2 R5 ciphertext", ct, exp);
        check(lat == 13 && pls, "R6 R7 timing in sweep", 64'(lat), 64'd13);
      end
    end

    // R10 back-to-back: second block waits and is taken right after first result
    in_valid = 1'b1;
    in_block = 64'h1111_2222_3333_4444;
    @(negedge clk);
    in_block = 64'h5555_6666_7777_8888;
    while (!out_valid) @(negedge clk);
    ct = out_block;
    @(negedge clk);
    in_valid = 1'b0;
    gap = 1;
    while (!out_valid && gap < 60) begin @(negedge clk); gap++; end
    ct2 = out_block;
    exp = ref_enc(keys[3], 64'h1111_2222_3333_4444);
    check(ct == exp, "R10 first of pair", ct, exp);
    exp = ref_enc(keys[3], 64'h5555_6666_7777_8888);
    check(ct2 == exp, "R10 second of pair", ct2, exp);
    check(gap == 13, "R10 gap between results", 64'(gap), 64'd13);
    @(negedge clk);

    // R8 key load during a block is ignored
    in_valid = 1'b1;
    in_block = 64'hCAFE_0000_BEEF_0001;
    key_in   = keys[1];
    key_load = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(key_busy == 1'b0, "R8 load at accept ignored", 64'(key_busy), 64'd0);
    repeat (3) @(negedge clk);
    @(negedge clk);
    key_load = 1'b0;
    check(key_busy == 1'b0, "R8 load in flight ignored", 64'(key_busy), 64'd0);
    while (!out_valid) @(negedge clk);
    exp = ref_enc(keys[3], 64'hCAFE_0000_BEEF_0001);
    check(out_block == exp, "R8 result uses old key", out_block, exp);
    @(negedge clk);

    // R9 restart in mid-expansion
    key_load = 1'b1;
    key_in   = keys[2];
    @(negedge clk);
    key_load = 1'b0;
    repeat (20) @(negedge clk);
    load_key(keys[1], blen);
    check(blen == 78, "R9 busy length after restart", 64'(blen), 64'd78);
    run_block(64'h0123_4567_89AB_CDEF, ct, lat, rdy, pls);
    exp = ref_enc(keys[1], 64'h0123_4567_89AB_CDEF);
    check(ct == exp, "R9 result uses restarted key", ct, exp);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule